// File: doc/BRIEF.md
# Four-Phase Handshake Pipeline Stage Controller

This block is the control half of one stage in a self-timed FIFO pipeline, recast as clocked logic. It sits between a left (upstream) neighbour and a right (downstream) neighbour. On its left side it receives a request and returns an acknowledge. On its right side it issues a request and receives an acknowledge. Both sides use return-to-zero (four-phase) signalling.

The controller is made of two clocked C-element registers. Each register copies its two inputs when they agree and otherwise keeps its value.
- The left acknowledge joins the left request with the inverted right request.
- The right request joins the left acknowledge with the inverted right acknowledge.

Through this cross-coupled feedback the left acknowledge and the right request must take turns: each change of one must be answered by a change of the other. A one-cycle marker output flags every rising edge of the right request. A data latch would capture the stage's payload at that point.

Top module: `hs_stage_ctrl`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `lack_o`, `rreq_o` and `cap_o` are all 0.
- R2: When `lreq_i` is 1 and `rreq_o` is 0 at a clock edge, `lack_o` is 1 after that edge. When `lreq_i` is 0 and `rreq_o` is 1, `lack_o` is 0 after the edge.
- R3: When `lack_o` is 1 and `rack_i` is 0 at a clock edge, `rreq_o` is 1 after that edge. When `lack_o` is 0 and `rack_i` is 1, `rreq_o` is 0 after the edge. Every change of `rreq_o` takes the value `lack_o` had before the edge.
- R4: `lack_o` keeps its value while `lreq_i` equals `rreq_o`. In particular, a new left request made while `rreq_o` is still 1 is not acknowledged until `rreq_o` has returned to 0.
- R5: `rreq_o` keeps its value while `lack_o` equals `rack_i`. In particular, `rreq_o` does not fall before `rack_i` is 1, and it does not rise again before `rack_i` has returned to 0.
- R6: `lack_o` and `rreq_o` alternate. `lack_o` changes only on an edge where it equals `rreq_o`. `rreq_o` changes only on an edge where it differs from `lack_o`. The two therefore never change on the same edge.
- R7: `cap_o` is 1 for exactly the one cycle in which `rreq_o` has just risen from 0 to 1. It is 0 in every other cycle.
- R8: A change of `lack_o` always takes the value `lreq_i` had before the edge. A change of `rreq_o` happens only when `rack_i` equaled the previous `rreq_o`, that is, when the previous phase had been acknowledged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state updates on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset; clears all state to 0 |
| lreq_i | input | 1 | Request from the left neighbour |
| lack_o | output | 1 | Acknowledge to the left neighbour |
| rreq_o | output | 1 | Request to the right neighbour |
| rack_i | input | 1 | Acknowledge from the right neighbour |
| cap_o | output | 1 | One-cycle marker on each rising edge of `rreq_o` (latch capture point) |

## Verification
The ordering properties hold for any input sequence, because they depend only on how the C-elements combine their inputs. They do not assume that the neighbours obey the protocol. Only the reading of the outputs as a clean A+, Y+, Z+, B+ round relies on the neighbours behaving properly:
- the left neighbour changes `lreq_i` only after `lack_o` has matched it;
- the right neighbour changes `rack_i` only after `rreq_o` has moved away from it.

The stimulus keeps to this. Both neighbour models wait for the opposite output before each transition, with random delays of zero to four cycles in between. The directed scenarios deliberately raise a new left request early and hold back the right acknowledge, to expose the hold behaviour.

// File: rtl/hs_stage_pkg.sv
package hs_stage_pkg;

  // Majority form of a C-element: follow the inputs when they agree, else hold.
  function automatic logic c_join(input logic a, input logic b, input logic hold);
    return (a & b) | (hold & (a | b));
  endfunction

  // True when a level is about to go from 0 to 1.
  function automatic logic rises(input logic cur, input logic nxt);
    return nxt & ~cur;
  endfunction

endpackage

// File: rtl/hs_celem.sv
module hs_celem
  import hs_stage_pkg::*;
#(
  parameter int   W       = 1,
  parameter bit   INV_B   = 1'b0,
  parameter logic RST_VAL = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] q_o,
  output logic [W-1:0] nxt_o,
  output logic [W-1:0] step_o
);

  logic [W-1:0] b_eff;
  logic [W-1:0] q_r;

  for (genvar gi = 0; gi < W; gi++) begin : g_bit
    if (INV_B) begin : g_inv
      assign b_eff[gi] = ~b_i[gi];
    end else begin : g_pass
      assign b_eff[gi] = b_i[gi];
    end
    assign nxt_o[gi]  = c_join(a_i[gi], b_eff[gi], q_r[gi]);
    assign step_o[gi] = nxt_o[gi] ^ q_r[gi];

    always_ff @(posedge clk) begin
      if (!rst_n) q_r[gi] <= RST_VAL;
      else        q_r[gi] <= nxt_o[gi];
    end
  end

  assign q_o = q_r;

endmodule

// File: rtl/hs_rise_mark.sv
module hs_rise_mark
  import hs_stage_pkg::*;
#(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] cur_i,
  input  logic [W-1:0] nxt_i,
  output logic [W-1:0] mark_o
);

  logic [W-1:0] mark_r;

  for (genvar gi = 0; gi < W; gi++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n) mark_r[gi] <= 1'b0;
      else        mark_r[gi] <= rises(cur_i[gi], nxt_i[gi]);
    end
  end

  assign mark_o = mark_r;

  AST_MARK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (mark_o != '0) |=> ((mark_o & $past(mark_o)) == '0)); // R7

endmodule

// File: rtl/hs_stage_ctrl.sv
module hs_stage_ctrl
  import hs_stage_pkg::*;
#(
  parameter logic IDLE_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lreq_i,
  output logic lack_o,
  output logic rreq_o,
  input  logic rack_i,
  output logic cap_o
);

  localparam int LW = 1;

  // Named internal events, brought out for the assertions.
  logic lack_q, lack_nxt, lack_step;
  logic rreq_q, rreq_nxt, rreq_step;

  // Left acknowledge: join of left request and inverted right request.
  hs_celem #(.W(LW), .INV_B(1'b1), .RST_VAL(IDLE_VAL)) u_left_join (
    .clk    (clk),
    .rst_n  (rst_n),
    .a_i    (lreq_i),
    .b_i    (rreq_q),
    .q_o    (lack_q),
    .nxt_o  (lack_nxt),
    .step_o (lack_step)
  );

  // Right request: join of left acknowledge and inverted right acknowledge.
  hs_celem #(.W(LW), .INV_B(1'b1), .RST_VAL(IDLE_VAL)) u_right_join (
    .clk    (clk),
    .rst_n  (rst_n),
    .a_i    (lack_q),
    .b_i    (rack_i),
    .q_o    (rreq_q),
    .nxt_o  (rreq_nxt),
    .step_o (rreq_step)
  );

  // Capture marker on each rising edge of the right request.
  hs_rise_mark #(.W(LW)) u_cap_mark (
    .clk    (clk),
    .rst_n  (rst_n),
    .cur_i  (rreq_q),
    .nxt_i  (rreq_nxt),
    .mark_o (cap_o)
  );

  assign lack_o = lack_q;
  assign rreq_o = rreq_q;

  // Assertions
  AST_RESET_IDLE: assert property (@(posedge clk)
    !rst_n |=> (!lack_o && !rreq_o && !cap_o)); // R1

  AST_NO_DOUBLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !(lack_step && rreq_step)); // R6

  AST_LACK_TURN: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(lack_o) |-> ($past(lack_o) == $past(rreq_o))); // R6

  AST_RREQ_TURN: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rreq_o) |-> ($past(lack_o) != $past(rreq_o))); // R6

  AST_LACK_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(lack_o) |-> (lack_o == $past(lreq_i))); // R8

  AST_RREQ_FOLLOWS_LACK: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rreq_o) |-> (rreq_o == $past(lack_o))); // R3

  AST_RREQ_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rreq_o) |-> ($past(rack_i) == $past(rreq_o))); // R8

  AST_LACK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (lreq_i == rreq_o) |=> $stable(lack_o)); // R4

  AST_RREQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (lack_o == rack_i) |=> $stable(rreq_o)); // R5

  AST_CAP_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    cap_o |-> (rreq_o && !$past(rreq_o))); // R7

  AST_RISE_HAS_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rreq_o) |-> cap_o); // R7

endmodule

// File: tb/hs_stage_ctrl_bench.sv
`timescale 1ns/1ps
module hs_stage_ctrl_bench;

  logic clk = 1'b0;
  logic rst_n;
  logic lreq, rack;
  logic lack, rreq, cap;

  int checks = 0;
  int errors = 0;
  bit mon_en = 1'b0;

  always #10 clk = ~clk;   // 50 MHz

  hs_stage_ctrl u_hs_stage_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .lreq_i (lreq),
    .lack_o (lack),
    .rreq_o (rreq),
    .rack_i (rack),
    .cap_o  (cap)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic step(); @(negedge clk); endtask

  task automatic do_reset();
    rst_n = 1'b0; lreq = 1'b0; rack = 1'b0;
    repeat (3) step();
    check(lack == 0 && rreq == 0 && cap == 0, "R1", "outputs in reset",
          {lack, rreq, cap}, 0);
    rst_n = 1'b1;
    step();
    check(lack == 0 && rreq == 0 && cap == 0, "R1", "outputs after release",
          {lack, rreq, cap}, 0);
  endtask

  // Protocol-order monitor: samples pre-edge values at posedge, checks 5 ns later.
  always @(posedge clk) begin
    logic in_a, in_b, old_y, old_z;
    in_a = lreq; in_b = rack; old_y = lack; old_z = rreq;
    #5;
    if (mon_en && rst_n) begin
      if (lack != old_y) begin
        check(lack == in_a, "R8", "lack change value vs prior lreq", lack, in_a);
        check(old_y == old_z, "R6", "lack moved out of turn", old_z, old_y);
      end
      if (rreq != old_z) begin
        check(rreq == old_y, "R3", "rreq change value vs prior lack", rreq, old_y);
        check(in_b == old_z, "R8", "rreq moved before ack", in_b, old_z);
        check(old_y != old_z, "R6", "rreq moved out of turn", old_y, !old_z);
      end
      if (cap || (rreq && !old_z))
        check(cap == (rreq && !old_z), "R7", "capture marker", cap, rreq && !old_z);
    end
  end

  // Directed: one full round, A+ Y+ Z+ B+ with exact cycle timing.
  task automatic t_basic_round();
    do_reset();
    lreq = 1'b1; step();
    check(lack == 1, "R2", "lack rises one edge after lreq", lack, 1);
    check(rreq == 0 && cap == 0, "R6", "rreq still low with lack rise", rreq, 0);
    step();
    check(rreq == 1, "R3", "rreq rises one edge after lack", rreq, 1);
    check(cap == 1, "R7", "marker in rise cycle", cap, 1);
    step();
    check(cap == 0, "R7", "marker lasts one cycle", cap, 0);
    check(rreq == 1 && lack == 1, "R5", "both hold before ack", {lack, rreq}, 3);
    rack = 1'b1; lreq = 1'b0; step();
    check(lack == 0, "R2", "lack falls after lreq drop with rreq high", lack, 0);
    step();
    check(rreq == 0, "R3", "rreq falls after lack low and rack high", rreq, 0);
    rack = 1'b0; step();
    check(lack == 0 && rreq == 0 && cap == 0, "R1", "idle after round",
          {lack, rreq, cap}, 0);
  endtask

  // Directed: early new request and late right acknowledge are both held off.
  task automatic t_hold_off();
    do_reset();
    lreq = 1'b1; repeat (2) step();
    lreq = 1'b0; step();
    check(lack == 0, "R2", "lack returns to 0", lack, 0);
    check(rreq == 1, "R5", "rreq holds without rack", rreq, 1);
    lreq = 1'b1;
    for (int i = 0; i < 3; i++) begin
      step();
      check(lack == 0, "R4", "early lreq not acknowledged", lack, 0);
      check(rreq == 1, "R5", "rreq holds without rack", rreq, 1);
    end
    rack = 1'b1; step();
    check(rreq == 0, "R3", "rreq falls on rack", rreq, 0);
    check(lack == 0, "R6", "lack waits its turn", lack, 0);
    step();
    check(lack == 1, "R4", "pending lreq accepted after rreq low", lack, 1);
    for (int i = 0; i < 2; i++) begin
      step();
      check(rreq == 0 && cap == 0, "R5", "rreq held while rack still 1",
            {rreq, cap}, 0);
    end
    rack = 1'b0; step();
    check(rreq == 1 && cap == 1, "R3", "rreq rises once rack returns",
          {rreq, cap}, 3);
    lreq = 1'b0; rack = 1'b1; repeat (2) step();
    rack = 1'b0; step();
    check(lack == 0 && rreq == 0, "R1", "idle after hold test", {lack, rreq}, 0);
  endtask

  // Random: neighbours with random response delays.
  task automatic t_random_rounds(input int n);
    int caps;
    do_reset();
    mon_en = 1'b1;
    caps = 0;
    fork
      for (int r = 0; r < n; r++) begin
        repeat ($urandom_range(0, 4)) step();
        lreq = 1'b1;
        while (lack !== 1'b1) step();
        repeat ($urandom_range(0, 4)) step();
        lreq = 1'b0;
        while (lack !== 1'b0) step();
      end
      for (int r = 0; r < n; r++) begin
        while (rreq !== 1'b1) step();
        repeat ($urandom_range(0, 4)) step();
        rack = 1'b1;
        while (rreq !== 1'b0) step();
        repeat ($urandom_range(0, 4)) step();
        rack = 1'b0;
      end
      for (int c = 0; c < 4 * n * 12; c++) begin
        step();
        if (cap) caps++;
      end
    join_any
    wait fork;
    mon_en = 1'b0;
    check(caps == n, "R7", "one marker per round", caps, n);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "R1", "watchdog expired", 0, 1);
    summary();
  end

  initial begin
    rst_n = 1'b0; lreq = 1'b0; rack = 1'b0;
    t_basic_round();
    t_hold_off();
    t_random_rounds(200);
    summary();
  end

endmodule